// File: doc/BRIEF.md
# Overcurrent Fault and Soft-Start Sequencer

This block supervises start-up and fault recovery for a phase-shifted bridge modulator. It holds a digital soft-start level that climbs by one step every `TICK_DIV` clocks. The level caps the control word that reaches the phase modulator, so power builds up gradually after power-good and after every fault. The analog parts are modelled as inputs: the comparators arrive as flags and the timing capacitor is the counter.

A hard overcurrent flag sets a fault latch and turns the bridge off in the same cycle. The soft-start level then drains in steps down to a low floor. Once the flag is gone and the floor is reached, the bridge switches again, but at zero phase. The latch releases only when the level has recharged to a restart threshold near the top. This holds even when the fault struck early in a ramp. A separate soft limit flag asks the modulator to stop widening the phase on the present cycle. It takes effect only while the demand is above the ramp.

Top module: `ocp_softstart_seq`

## Requirements
- R1: While `uv_ok` is 0 (and out of reset), `bridge_off` is 1 and `ctrl_word` is 0. A clock edge seen with `uv_ok` at 0 sets `ss_level` to 0.
- R2: In a ramping phase, `ss_level` rises by exactly 1 every `TICK_DIV` (default 4) clocks. The first step lands `TICK_DIV` edges after the edge that entered the phase. The level stops at 2^`SS_W`-1 (255).
- R3: With the latch clear and the bridge on, `ctrl_word` equals the smaller of `demand` and `ss_level`.
- R4: `cs_hard` at 1 forces `bridge_off` to 1 and `ctrl_word` to 0 in the same cycle, with no clock edge needed.
- R5: While the latch is set and the bridge is off, `ss_level` drops by `DIS_STEP` (4) per clock and stops at `LOW_LVL` (3). A level already at or below `LOW_LVL` is kept as it is.
- R6: As long as `cs_hard` stays 1, `bridge_off` stays 1, even after the discharge has ended.
- R7: On the first edge that sees `cs_hard` at 0 with the level at or below `LOW_LVL`, the bridge turns on with `zero_phase` 1 and `ctrl_word` 0. The level then stays unchanged for `TICK_DIV` edges before it begins to rise.
- R8: `zero_phase` stays 1 until `ss_level` has reached `RESTART_LVL` (250). It drops on the following edge, after which R3 applies. This also holds after a fault that came while the level was still low.
- R9: `limit_hold` is 1 only when `cs_soft` and `demand_gt_ramp` are both 1 while the bridge is on. Either flag alone, or any state with the bridge off, gives 0.
- R10: Loss of `uv_ok` outranks the fault latch. A hard fault seen only during undervoltage leaves no latch once `uv_ok` returns, and the next start-up ramp runs with `zero_phase` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uv_ok | input | 1 | Supply and reference valid |
| cs_soft | input | 1 | Current above the cycle-limit threshold |
| cs_hard | input | 1 | Current above the hard-fault threshold |
| demand_gt_ramp | input | 1 | Control demand currently exceeds the ramp |
| demand | input | SS_W | Requested control word |
| bridge_off | output | 1 | Force all bridge drives low |
| zero_phase | output | 1 | Bridge switches with zero phase shift |
| limit_hold | output | 1 | Hold phase shift on this cycle |
| ss_level | output | SS_W | Present soft-start level |
| ctrl_word | output | SS_W | Control word after clamping |

## Verification
`bridge_off`, `zero_phase`, `limit_hold` and `ctrl_word` follow their inputs combinationally. The bench samples them 1 ns after it drives those inputs on a falling edge. `ss_level` and every state change pass through one register, so they are checked on the falling edge after the rising edge that makes them change. The ramp is checked at exact edge counts: still 0 after `TICK_DIV` edges, 1 after one more edge. The discharge is checked one edge at a time. The release of the latch is checked at the level of 250 and again on the edge after it.

// File: rtl/ocp_ss_pkg.sv
package ocp_ss_pkg;
   typedef enum logic [1:0] {
      ST_UVLO  = 2'd0,
      ST_FAULT = 2'd1,
      ST_RECHG = 2'd2,
      ST_RUN   = 2'd3
   } seq_st_e;

   typedef enum logic [1:0] {
      SS_HOLD  = 2'd0,
      SS_CLEAR = 2'd1,
      SS_DIS   = 2'd2,
      SS_RAMP  = 2'd3
   } ss_cmd_e;
endpackage

// File: rtl/ocp_ss_counter.sv
module ocp_ss_counter
   import ocp_ss_pkg::*;
#(
   parameter int SS_W     = 8,
   parameter int TICK_DIV = 4,
   parameter int LOW_LVL  = 3,
   parameter int DIS_STEP = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  ss_cmd_e         cmd,
   output logic [SS_W-1:0] ss
);
   localparam logic [SS_W-1:0] TOP_V  = {SS_W{1'b1}};
   localparam logic [SS_W-1:0] LOW_V  = SS_W'(LOW_LVL);
   localparam logic [SS_W-1:0] STEP_V = SS_W'(DIS_STEP);
   localparam logic [SS_W-1:0] THR_V  = SS_W'(LOW_LVL + DIS_STEP);

   logic tick;
   logic [SS_W-1:0] ss_dis;

   // rate prescaler: one variant per divide setting
   generate
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick = (cmd == SS_RAMP);
      end else begin : g_div
         localparam int PW = $clog2(TICK_DIV);
         localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] pre;
         always_ff @(posedge clk) begin
            if (!rst_n || cmd != SS_RAMP) pre <= '0;
            else if (pre == LAST)         pre <= '0;
            else                          pre <= pre + 1'b1;
         end
         assign tick = (cmd == SS_RAMP) && (pre == LAST);
      end
   endgenerate

   // discharge: one jump to the floor, or a fixed step per clock
   generate
      if (DIS_STEP == 0) begin : g_dis_jump
         assign ss_dis = (ss > LOW_V) ? LOW_V : ss;
      end else begin : g_dis_step
         always_comb begin
            if (ss > THR_V)      ss_dis = ss - STEP_V;
            else if (ss > LOW_V) ss_dis = LOW_V;
            else                 ss_dis = ss;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ss <= '0;
      else begin
         unique case (cmd)
            SS_CLEAR: ss <= '0;
            SS_DIS:   ss <= ss_dis;
            SS_RAMP:  if (tick && ss != TOP_V) ss <= ss + 1'b1;
            default:  ss <= ss;
         endcase
      end
   end
endmodule

// File: rtl/ocp_ss_fsm.sv
module ocp_ss_fsm
   import ocp_ss_pkg::*;
#(
   parameter int SS_W        = 8,
   parameter int LOW_LVL     = 3,
   parameter int RESTART_LVL = 250
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            uv_ok,
   input  logic            cs_hard,
   input  logic [SS_W-1:0] ss,
   output seq_st_e         state,
   output ss_cmd_e         cmd
);
   localparam logic [SS_W-1:0] LOW_V = SS_W'(LOW_LVL);
   localparam logic [SS_W-1:0] RST_V = SS_W'(RESTART_LVL);

   seq_st_e nxt;

   always_comb begin
      nxt = state;
      if (!uv_ok) nxt = ST_UVLO;
      else begin
         unique case (state)
            ST_UVLO:  nxt = cs_hard ? ST_FAULT : ST_RUN;
            ST_RUN:   nxt = cs_hard ? ST_FAULT : ST_RUN;
            ST_FAULT: nxt = (!cs_hard && ss <= LOW_V) ? ST_RECHG : ST_FAULT;
            ST_RECHG: begin
               if (cs_hard)          nxt = ST_FAULT;
               else if (ss >= RST_V) nxt = ST_RUN;
               else                  nxt = ST_RECHG;
            end
            default:  nxt = ST_UVLO;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_UVLO;
      else        state <= nxt;
   end

   always_comb begin
      if (!uv_ok || state == ST_UVLO)           cmd = SS_CLEAR;
      else if (cs_hard || state == ST_FAULT)    cmd = SS_DIS;
      else if (state == ST_RUN || state == ST_RECHG) cmd = SS_RAMP;
      else                                      cmd = SS_HOLD;
   end
endmodule

// File: rtl/ocp_ss_outmux.sv
module ocp_ss_outmux
   import ocp_ss_pkg::*;
#(
   parameter int SS_W = 8
) (
   input  seq_st_e         state,
   input  logic            uv_ok,
   input  logic            cs_hard,
   input  logic            cs_soft,
   input  logic            demand_gt_ramp,
   input  logic [SS_W-1:0] demand,
   input  logic [SS_W-1:0] ss,
   output logic            bridge_off,
   output logic            zero_phase,
   output logic            limit_hold,
   output logic [SS_W-1:0] ctrl_word
);
   logic [SS_W-1:0] clamped;

   assign clamped    = (demand < ss) ? demand : ss;
   assign bridge_off = !uv_ok || cs_hard || state == ST_UVLO || state == ST_FAULT;
   assign zero_phase = !bridge_off && state == ST_RECHG;
   assign limit_hold = !bridge_off && cs_soft && demand_gt_ramp;
   assign ctrl_word  = (!bridge_off && state == ST_RUN) ? clamped : '0;
endmodule

// File: rtl/ocp_softstart_seq.sv
module ocp_softstart_seq
   import ocp_ss_pkg::*;
#(
   parameter int SS_W        = 8,
   parameter int TICK_DIV    = 4,
   parameter int LOW_LVL     = 3,
   parameter int DIS_STEP    = 4,
   parameter int RESTART_LVL = 250
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            uv_ok,
   input  logic            cs_soft,
   input  logic            cs_hard,
   input  logic            demand_gt_ramp,
   input  logic [SS_W-1:0] demand,
   output logic            bridge_off,
   output logic            zero_phase,
   output logic            limit_hold,
   output logic [SS_W-1:0] ss_level,
   output logic [SS_W-1:0] ctrl_word
);
   localparam int TOP = (1 << SS_W) - 1;

   // elaboration-time parameter checks
   generate
      if (SS_W < 2 || SS_W > 16) begin : g_bad_w
         $error("SS_W out of range");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (LOW_LVL + DIS_STEP >= RESTART_LVL) begin : g_bad_low
         $error("floor plus step must sit below the restart level");
      end
      if (RESTART_LVL > TOP) begin : g_bad_rst
         $error("RESTART_LVL exceeds the soft-start range");
      end
   endgenerate

   seq_st_e state;
   ss_cmd_e cmd;

   ocp_ss_fsm #(.SS_W(SS_W), .LOW_LVL(LOW_LVL), .RESTART_LVL(RESTART_LVL)) u_fsm (
      .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .cs_hard(cs_hard),
      .ss(ss_level), .state(state), .cmd(cmd));

   ocp_ss_counter #(.SS_W(SS_W), .TICK_DIV(TICK_DIV), .LOW_LVL(LOW_LVL),
                    .DIS_STEP(DIS_STEP)) u_ctr (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .ss(ss_level));

   ocp_ss_outmux #(.SS_W(SS_W)) u_out (
      .state(state), .uv_ok(uv_ok), .cs_hard(cs_hard), .cs_soft(cs_soft),
      .demand_gt_ramp(demand_gt_ramp), .demand(demand), .ss(ss_level),
      .bridge_off(bridge_off), .zero_phase(zero_phase),
      .limit_hold(limit_hold), .ctrl_word(ctrl_word));
endmodule

// File: rtl/ocp_ss_chk.sv
module ocp_ss_chk #(
   parameter int SS_W        = 8,
   parameter int RESTART_LVL = 250
) (
   input logic            clk,
   input logic            rst_n,
   input logic            uv_ok,
   input logic            cs_soft,
   input logic            cs_hard,
   input logic            demand_gt_ramp,
   input logic [SS_W-1:0] demand,
   input logic            bridge_off,
   input logic            zero_phase,
   input logic            limit_hold,
   input logic [SS_W-1:0] ss_level,
   input logic [SS_W-1:0] ctrl_word
);
   p_uv_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !uv_ok |=> ss_level == '0);

   p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_level > $past(ss_level)) |-> (ss_level == $past(ss_level) + 1'b1));

   p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word != '0) |-> (ctrl_word <= ss_level && ctrl_word <= demand));

   p_hard_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hard |-> (bridge_off && ctrl_word == '0));

   p_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hard |=> ss_level <= $past(ss_level));

   p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      zero_phase |-> (!bridge_off && ctrl_word == '0));

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(zero_phase) && uv_ok && !cs_hard) |-> ss_level >= SS_W'(RESTART_LVL));

   p_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      limit_hold |-> (cs_soft && demand_gt_ramp && !bridge_off));
endmodule

bind ocp_softstart_seq ocp_ss_chk #(.SS_W(SS_W), .RESTART_LVL(RESTART_LVL)) u_chk (
   .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .cs_soft(cs_soft), .cs_hard(cs_hard),
   .demand_gt_ramp(demand_gt_ramp), .demand(demand), .bridge_off(bridge_off),
   .zero_phase(zero_phase), .limit_hold(limit_hold), .ss_level(ss_level),
   .ctrl_word(ctrl_word));

// File: tb/ocp_softstart_seq_test.sv
`timescale 1ns/1ps
module ocp_softstart_seq_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uv_ok = 1'b0, cs_soft = 1'b0, cs_hard = 1'b0, dgr = 1'b0;
   logic [7:0] demand = 8'd0;
   logic bridge_off, zero_phase, limit_hold;
   logic [7:0] ss_level, ctrl_word;
   int n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   ocp_softstart_seq uut (
      .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .cs_soft(cs_soft),
      .cs_hard(cs_hard), .demand_gt_ramp(dgr), .demand(demand),
      .bridge_off(bridge_off), .zero_phase(zero_phase),
      .limit_hold(limit_hold), .ss_level(ss_level), .ctrl_word(ctrl_word));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ss(input int v);
      while (ss_level != 8'(v)) @(negedge clk);
   endtask

   task automatic t_reset;
      cs_soft = 1'b1; dgr = 1'b1; #1;
      chk("R1 bridge_off in reset", bridge_off, 1);
      chk("R1 ss_level in reset", ss_level, 0);
      chk("R1 ctrl_word in reset", ctrl_word, 0);
      chk("R9 no hold when off", limit_hold, 0);
      cs_soft = 1'b0; dgr = 1'b0;
   endtask

   task automatic t_ramp;
      demand = 8'd200;
      uv_ok = 1'b1;
      edges(4);
      chk("R2 still 0 after TICK_DIV edges", ss_level, 0);
      chk("R2 bridge on", bridge_off, 0);
      chk("R10 no zero phase on clean start", zero_phase, 0);
      edges(1);
      chk("R2 first step", ss_level, 1);
      edges(4);
      chk("R2 second step", ss_level, 2);
      chk("R3 clamp to ss", ctrl_word, 2);
      demand = 8'd1; #1;
      chk("R3 clamp to demand", ctrl_word, 1);
      demand = 8'd200;
      wait_ss(255);
      edges(8);
      chk("R2 saturate at top", ss_level, 255);
      chk("R3 demand below top", ctrl_word, 200);
   endtask

   task automatic t_limit;
      cs_soft = 1'b1; dgr = 1'b0; #1;
      chk("R9 soft flag alone", limit_hold, 0);
      cs_soft = 1'b0; dgr = 1'b1; #1;
      chk("R9 demand flag alone", limit_hold, 0);
      cs_soft = 1'b1; #1;
      chk("R9 both flags", limit_hold, 1);
      cs_soft = 1'b0; dgr = 1'b0;
   endtask

   task automatic t_fault_run;
      cs_hard = 1'b1; cs_soft = 1'b1; dgr = 1'b1; #1;
      chk("R4 immediate off", bridge_off, 1);
      chk("R4 ctrl zero", ctrl_word, 0);
      chk("R9 no hold during fault", limit_hold, 0);
      cs_soft = 1'b0; dgr = 1'b0;
      edges(1);
      chk("R5 first discharge step", ss_level, 251);
      edges(1);
      chk("R5 second discharge step", ss_level, 247);
      edges(70);
      chk("R5 floor level", ss_level, 3);
      chk("R6 held off while fault persists", bridge_off, 1);
      cs_hard = 1'b0;
      edges(1);
      chk("R7 bridge back on", bridge_off, 0);
      chk("R7 zero phase", zero_phase, 1);
      chk("R7 ctrl zero", ctrl_word, 0);
      edges(3);
      chk("R7 level unchanged before ramp", ss_level, 3);
      edges(1);
      chk("R7 ramp starts", ss_level, 4);
      wait_ss(249);
      chk("R8 latch held at 249", zero_phase, 1);
      wait_ss(250);
      chk("R8 latch held at 250", zero_phase, 1);
      edges(1);
      chk("R8 latch released", zero_phase, 0);
      chk("R8 clamp resumes", ctrl_word, 200);
   endtask

   task automatic t_uv_and_early;
      uv_ok = 1'b0; #1;
      chk("R1 off on uv loss", bridge_off, 1);
      edges(1);
      chk("R1 level cleared", ss_level, 0);
      cs_hard = 1'b1;
      edges(1);
      cs_hard = 1'b0;
      edges(1);
      chk("R10 off during uv", bridge_off, 1);
      chk("R10 level 0 during uv", ss_level, 0);
      uv_ok = 1'b1;
      edges(1);
      chk("R10 no latch after uv", zero_phase, 0);
      chk("R10 bridge on", bridge_off, 0);
      wait_ss(1);
      cs_hard = 1'b1;
      edges(1);
      cs_hard = 1'b0;
      chk("R5 low level kept", ss_level, 1);
      chk("R6 off after early fault", bridge_off, 1);
      edges(1);
      chk("R7 zero phase after early fault", zero_phase, 1);
      wait_ss(200);
      chk("R8 full charge needed", zero_phase, 1);
      wait_ss(250);
      edges(1);
      chk("R8 released after early fault", zero_phase, 0);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      finish_run();
   end

   initial begin
      edges(3);
      t_reset();
      rst_n = 1'b1;
      edges(2);
      t_reset();
      t_ramp();
      t_limit();
      t_fault_run();
      t_uv_and_early();
      finish_run();
   end
endmodule